// File: doc/BRIEF.md
# Dual-Output Switch Control Slave (two-wire bus)

This block is the serial control front end of a two-output audio/video routing switch. It watches an oversampled two-wire bus (SCL and SDA) with the system clock and finds START, repeated START and STOP conditions. It answers at one of two 7-bit device addresses; an address-select pin picks which one. A write transaction loads two control bytes, one per output. The block drives them as parallel buses to the analog switch fabric.

A read transaction returns one status byte. The byte holds a flag that is set after reset and clears once a status read has started. It also holds the level of two three-level sense pins. Comparators outside this block quantise each pin to a 2-bit code. SDA is open-drain: the block only ever asserts a pull-low enable.

Top module: `avsw_i2c_ctrl`

## Requirements
- R1: The device answers the 7-bit address {6'b100100, addr_sel}. With addr_sel low the write/read bytes are 0x90/0x91, and with addr_sel high they are 0x92/0x93. A non-matching address byte is not acknowledged. The block then ignores the bus, including any byte that looks like its own address, until the next START.
- R2: Bits are sampled on SCL rising edges, MSB first. Each byte the block accepts is acknowledged by pulling SDA low during the ninth clock. The block only starts pulling SDA low while SCL is low.
- R3: In a write, the first data byte after the address replaces ctrl1_o and the second replaces ctrl2_o. Each register changes once its eighth bit has been clocked in, and only while SCL is low. Bit 7 is the audio gain, bit 6 the video mode, bits 5:3 the video source and bits 2:0 the audio source; the block passes all of them through unchanged.
- R4: Reset clears ctrl1_o and ctrl2_o to 0x00 and leaves SDA released.
- R5: A third or later data byte in a write is acknowledged and changes neither control register.
- R6: Status bit 7 is a power-on flag. It reads 1 on the first status read after reset. It clears when that read starts, so every later read returns 0 until the next reset.
- R7: Status bits 5:4 encode sense pin 1 and bits 3:2 encode sense pin 2, each pair as {OPEN, SEL}. Code 00 (low) gives 01, code 01 (middle) gives 00, code 10 (high) gives 10, and the unused code 11 gives 00. Bits 6, 1 and 0 read 0.
- R8: The sense codes are captured when the acknowledge of the read address ends, and again at the end of each master acknowledge. Changes after that point do not alter the byte being shifted out.
- R9: After the master's not-acknowledge, the block releases SDA and keeps it released until the next START.
- R10: A STOP or a new START at any point aborts the transaction. A partly received data byte is discarded, and control bytes that were already complete keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset (power-on) |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 1 | Selects the low address bit |
| sense1_i | input | 2 | Quantised level of sense pin 1 (00 low, 01 middle, 10 high) |
| sense2_i | input | 2 | Quantised level of sense pin 2 |
| ctrl1_o | output | 8 | Control register for output 1 |
| ctrl2_o | output | 8 | Control register for output 2 |

## Verification
The bench aims at byte boundaries: a fourth and fifth written byte, a STOP four bits into the second data byte, and a repeated START between a write and a read. A design that counted bytes wrong would corrupt a register that should have held its value. A design that committed partial bytes would load a half-shifted value. The bench also sends a data byte equal to the device's own address after an address mismatch, which catches a slave that resynchronises without a START. It reads status twice and changes the sense pins in the middle of a read. These catch a power-on flag that never clears or clears early, and sense bits sampled live instead of captured.

// File: rtl/avsw_pkg.sv
package avsw_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_WR_DATA,
      ST_WR_ACK,
      ST_RD_DATA,
      ST_RD_ACK,
      ST_IGNORE
   } fsm_state_t;

   // Three-level sense code to {open, sel}
   function automatic logic [1:0] sense_to_pair(input logic [1:0] code);
      case (code)
         2'b00:   return 2'b01;
         2'b10:   return 2'b10;
         default: return 2'b00;
      endcase
   endfunction

endpackage

// File: rtl/avsw_bus_cond.sv
module avsw_bus_cond #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic bus_start,
   output logic bus_stop
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("avsw_bus_cond: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] scl_sync_q;
   logic [SYNC_STAGES-1:0] sda_sync_q;
   logic                   scl_d_q;
   logic                   sda_d_q;
   logic                   scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sync_q <= '1;
         sda_sync_q <= '1;
         scl_d_q    <= 1'b1;
         sda_d_q    <= 1'b1;
      end else begin
         scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_i};
         sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_i};
         scl_d_q    <= scl_s;
         sda_d_q    <= sda_s;
      end
   end

   assign scl_s     = scl_sync_q[SYNC_STAGES-1];
   assign sda_s     = sda_sync_q[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_d_q;
   assign scl_fall  = ~scl_s & scl_d_q;
   assign bus_start = scl_s & scl_d_q & sda_d_q & ~sda_s;
   assign bus_stop  = scl_s & scl_d_q & ~sda_d_q & sda_s;

endmodule

// File: rtl/avsw_status.sv
module avsw_status #(
   parameter int SENSE_N = 2,
   parameter int DATA_W  = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   rd_start,
   input  logic [2*SENSE_N-1:0]   sense_i,
   output logic [DATA_W-1:0]      status_o
);

   localparam int TOP_FIELD = DATA_W - 3;

   if (2 * SENSE_N + 2 > DATA_W) begin : g_bad_fit
      $error("avsw_status: sense fields do not fit in the status byte");
   end

   logic                        por_q;
   logic [SENSE_N-1:0][1:0]     pair;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        por_q <= 1'b1;
      else if (rd_start) por_q <= 1'b0;
   end

   for (genvar p = 0; p < SENSE_N; p++) begin : g_pin
      assign pair[p] = avsw_pkg::sense_to_pair(sense_i[2*p +: 2]);
   end

   always_comb begin
      status_o           = '0;
      status_o[DATA_W-1] = por_q;
      for (int p = 0; p < SENSE_N; p++) begin
         status_o[TOP_FIELD-2*p -: 2] = pair[p];
      end
   end

endmodule

// File: rtl/avsw_ctrl_bank.sv
module avsw_ctrl_bank #(
   parameter int NUM_REGS = 2,
   parameter int DATA_W   = 8,
   parameter int IDX_W    = 2
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_en,
   input  logic [IDX_W-1:0]                  wr_idx,
   input  logic [DATA_W-1:0]                 wr_data,
   output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_o
);

   if ((1 << IDX_W) <= NUM_REGS) begin : g_bad_idx
      $error("avsw_ctrl_bank: IDX_W too narrow for NUM_REGS");
   end

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            regs_o[g] <= '0;
         else if (wr_en && (wr_idx == IDX_W'(g)))
            regs_o[g] <= wr_data;
      end
   end

endmodule

// File: rtl/avsw_slave_fsm.sv
module avsw_slave_fsm
   import avsw_pkg::*;
#(
   parameter int         NUM_REGS = 2,
   parameter int         DATA_W   = 8,
   parameter int         IDX_W    = 2,
   parameter logic [6:0] DEV_ADDR = 7'h48
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sda_s,
   input  logic               scl_rise,
   input  logic               scl_fall,
   input  logic               bus_start,
   input  logic               bus_stop,
   input  logic               addr_sel,
   input  logic [DATA_W-1:0]  status_i,
   output logic               sda_oe,
   output logic               rd_start,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic [DATA_W-1:0]  wr_data
);

   localparam int         CNT_W    = $clog2(DATA_W + 1);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);
   localparam logic [IDX_W-1:0] IDX_END = IDX_W'(NUM_REGS);

   if (DATA_W != 8) begin : g_bad_width
      $error("avsw_slave_fsm: the bus protocol moves 8-bit bytes");
   end

   fsm_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] shift_q;
   logic [IDX_W-1:0]  idx_q;
   logic              rw_q;
   logic              mack_q;
   logic [6:0]        my_addr;

   assign my_addr = {DEV_ADDR[6:1], addr_sel};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         cnt_q    <= '0;
         shift_q  <= '0;
         idx_q    <= '0;
         rw_q     <= 1'b0;
         mack_q   <= 1'b0;
         sda_oe   <= 1'b0;
         rd_start <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else begin
         rd_start <= 1'b0;
         wr_en    <= 1'b0;
         if (bus_start) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            sda_oe  <= 1'b0;
         end else if (bus_stop) begin
            state_q <= ST_IDLE;
            sda_oe  <= 1'b0;
         end else begin
            case (state_q)
               ST_ADDR: begin
                  if (scl_rise) begin
                     shift_q <= {shift_q[DATA_W-2:0], sda_s};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == FULL) begin
                     if (shift_q[7:1] == my_addr) begin
                        rw_q    <= shift_q[0];
                        sda_oe  <= 1'b1;
                        state_q <= ST_ADDR_ACK;
                     end else begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     cnt_q <= '0;
                     if (rw_q) begin
                        shift_q  <= status_i;
                        sda_oe   <= ~status_i[DATA_W-1];
                        rd_start <= 1'b1;
                        state_q  <= ST_RD_DATA;
                     end else begin
                        sda_oe  <= 1'b0;
                        idx_q   <= '0;
                        state_q <= ST_WR_DATA;
                     end
                  end
               end
               ST_WR_DATA: begin
                  if (scl_rise) begin
                     shift_q <= {shift_q[DATA_W-2:0], sda_s};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == FULL) begin
                     sda_oe  <= 1'b1;
                     state_q <= ST_WR_ACK;
                     if (idx_q < IDX_END) begin
                        wr_en   <= 1'b1;
                        wr_idx  <= idx_q;
                        wr_data <= shift_q;
                        idx_q   <= idx_q + 1'b1;
                     end
                  end
               end
               ST_WR_ACK: begin
                  if (scl_fall) begin
                     sda_oe  <= 1'b0;
                     cnt_q   <= '0;
                     state_q <= ST_WR_DATA;
                  end
               end
               ST_RD_DATA: begin
                  if (scl_fall) begin
                     if (cnt_q == LAST) begin
                        sda_oe  <= 1'b0;
                        mack_q  <= 1'b0;
                        state_q <= ST_RD_ACK;
                     end else begin
                        shift_q <= {shift_q[DATA_W-2:0], 1'b0};
                        sda_oe  <= ~shift_q[DATA_W-2];
                        cnt_q   <= cnt_q + 1'b1;
                     end
                  end
               end
               ST_RD_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        shift_q  <= status_i;
                        sda_oe   <= ~status_i[DATA_W-1];
                        rd_start <= 1'b1;
                        cnt_q    <= '0;
                        state_q  <= ST_RD_DATA;
                     end else begin
                        sda_oe  <= 1'b0;
                        state_q <= ST_IGNORE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/avsw_i2c_ctrl.sv
module avsw_i2c_ctrl #(
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] DEV_ADDR    = 7'h48
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   input  logic       addr_sel,
   input  logic [1:0] sense1_i,
   input  logic [1:0] sense2_i,
   output logic [7:0] ctrl1_o,
   output logic [7:0] ctrl2_o
);

   localparam int NUM_REGS = 2;
   localparam int DATA_W   = 8;
   localparam int SENSE_N  = 2;
   localparam int IDX_W    = $clog2(NUM_REGS + 1);

   if (DEV_ADDR[0] != 1'b0) begin : g_bad_addr
      $error("avsw_i2c_ctrl: DEV_ADDR bit 0 is supplied by addr_sel and must be 0");
   end

   logic                            sda_s, scl_rise, scl_fall, bus_start, bus_stop;
   logic                            rd_start, wr_en;
   logic [IDX_W-1:0]                wr_idx;
   logic [DATA_W-1:0]               wr_data, status;
   logic [NUM_REGS-1:0][DATA_W-1:0] regs;

   avsw_bus_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .bus_start(bus_start), .bus_stop(bus_stop)
   );

   avsw_status #(.SENSE_N(SENSE_N), .DATA_W(DATA_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .rd_start(rd_start),
      .sense_i({sense2_i, sense1_i}), .status_o(status)
   );

   avsw_slave_fsm #(
      .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W), .DEV_ADDR(DEV_ADDR)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop),
      .addr_sel(addr_sel), .status_i(status), .sda_oe(sda_oe),
      .rd_start(rd_start), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
   );

   avsw_ctrl_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .regs_o(regs)
   );

   assign ctrl1_o = regs[0];
   assign ctrl2_o = regs[1];

endmodule

// File: rtl/avsw_i2c_ctrl_chk.sv
module avsw_i2c_ctrl_chk
   import avsw_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       scl_i,
   input logic       sda_oe,
   input logic [7:0] ctrl1_o,
   input logic [7:0] ctrl2_o,
   input logic       por_flag,
   input fsm_state_t fsm_state
);

   assert_reset_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (ctrl1_o == 8'h00 && ctrl2_o == 8'h00 && !sda_oe));

   assert_ctrl_scl_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(ctrl1_o) || !$stable(ctrl2_o)) |-> !scl_i);

   assert_pull_scl_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_i);

   assert_por_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !por_flag |=> !por_flag);

   assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_state == ST_IGNORE) |-> !sda_oe);

endmodule

bind avsw_i2c_ctrl avsw_i2c_ctrl_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
   .ctrl1_o(ctrl1_o), .ctrl2_o(ctrl2_o),
   .por_flag(u_stat.por_q), .fsm_state(u_fsm.state_q)
);

// File: tb/avsw_i2c_ctrl_tb_top.sv
module avsw_i2c_ctrl_tb_top;

   localparam int Q = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic       addr_sel = 1'b0;
   logic [1:0] sense1 = 2'b00;
   logic [1:0] sense2 = 2'b10;
   logic       sda_oe;
   logic [7:0] ctrl1, ctrl2;
   logic       sda_line;
   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   assign sda_line = sda_m & ~sda_oe;

   avsw_i2c_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe(sda_oe), .addr_sel(addr_sel), .sense1_i(sense1),
      .sense2_i(sense2), .ctrl1_o(ctrl1), .ctrl2_o(ctrl2)
   );

   // sel, addr, d1, d2, ack expected, ctrl1 expected, ctrl2 expected
   localparam logic [41:0] VEC [6] = '{
      {1'b0, 8'h90, 8'hA5, 8'h3C, 1'b1, 8'hA5, 8'h3C},
      {1'b1, 8'h92, 8'h81, 8'h7E, 1'b1, 8'h81, 8'h7E},
      {1'b0, 8'h92, 8'h90, 8'h22, 1'b0, 8'h81, 8'h7E},
      {1'b1, 8'h90, 8'h92, 8'h44, 1'b0, 8'h81, 8'h7E},
      {1'b0, 8'h94, 8'h55, 8'h66, 1'b0, 8'h81, 8'h7E},
      {1'b0, 8'h90, 8'hFF, 8'h00, 1'b1, 8'hFF, 8'h00}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wait_q();
      repeat (Q) @(negedge clk);
   endtask

   task automatic do_bit(input logic b, output logic r);
      sda_m = b;  wait_q();
      scl_m = 1'b1; wait_q();
      r = sda_line;
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b0; wait_q();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wait_q();
      scl_m = 1'b1; wait_q();
      sda_m = 1'b1; wait_q();
   endtask

   task automatic wr_byte(input logic [7:0] b, output logic ack);
      logic r;
      for (int i = 7; i >= 0; i--) do_bit(b[i], r);
      do_bit(1'b1, r);
      ack = ~r;
   endtask

   task automatic rd_byte(input logic give_ack, output logic [7:0] d);
      logic r;
      for (int i = 7; i >= 0; i--) begin
         do_bit(1'b1, r);
         d[i] = r;
      end
      do_bit(~give_ack, r);
   endtask

   function automatic logic [7:0] exp_status(input logic por, input logic [1:0] s1,
                                             input logic [1:0] s2);
      logic [1:0] p1, p2;
      p1 = (s1 == 2'b00) ? 2'b01 : (s1 == 2'b10) ? 2'b10 : 2'b00;
      p2 = (s2 == 2'b00) ? 2'b01 : (s2 == 2'b10) ? 2'b10 : 2'b00;
      return {por, 1'b0, p1, p2, 2'b00};
   endfunction

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic       ack;
      logic [7:0] d;
      logic       r;

      repeat (5) @(negedge clk);
      chk("R4 ctrl1 in reset", {24'h0, ctrl1}, 32'h00);
      rst_n = 1'b1;
      wait_q();
      chk("R4 ctrl1 after reset", {24'h0, ctrl1}, 32'h00);
      chk("R4 ctrl2 after reset", {24'h0, ctrl2}, 32'h00);
      chk("R4 sda released", {31'h0, sda_oe}, 32'h0);

      // First status read: flag set, low / high sense levels
      bus_start();
      wr_byte(8'h91, ack);
      chk("R1 read address ack", {31'h0, ack}, 32'h1);
      rd_byte(1'b0, d);
      chk("R6 R7 first status", {24'h0, d}, {24'h0, exp_status(1'b1, 2'b00, 2'b10)});
      chk("R9 released after nack", {31'h0, sda_oe}, 32'h0);
      wait_q();
      chk("R9 still released", {31'h0, sda_line}, 32'h1);
      bus_stop();

      // Second read: flag cleared
      sense1 = 2'b10; sense2 = 2'b01;
      bus_start();
      wr_byte(8'h91, ack);
      rd_byte(1'b0, d);
      chk("R6 flag cleared", {24'h0, d}, {24'h0, exp_status(1'b0, 2'b10, 2'b01)});
      bus_stop();

      // Table of write transactions
      for (int k = 0; k < 6; k++) begin
         logic [41:0] v;
         logic        a1, a2;
         v = VEC[k];
         addr_sel = v[41];
         bus_start();
         wr_byte(v[40:33], ack);
         wr_byte(v[32:25], a1);
         wr_byte(v[24:17], a2);
         bus_stop();
         chk($sformatf("R1 R2 vec%0d address ack", k), {31'h0, ack}, {31'h0, v[16]});
         chk($sformatf("R1 vec%0d data ack", k), {30'h0, a1, a2}, {30'h0, v[16], v[16]});
         chk($sformatf("R3 vec%0d ctrl1", k), {24'h0, ctrl1}, {24'h0, v[15:8]});
         chk($sformatf("R3 vec%0d ctrl2", k), {24'h0, ctrl2}, {24'h0, v[7:0]});
      end
      addr_sel = 1'b0;

      // Extra bytes are acknowledged but dropped
      bus_start();
      wr_byte(8'h90, ack);
      wr_byte(8'h12, ack);
      wr_byte(8'h34, ack);
      wr_byte(8'h56, ack);
      chk("R5 third byte ack", {31'h0, ack}, 32'h1);
      wr_byte(8'h78, ack);
      bus_stop();
      chk("R5 ctrl1 kept", {24'h0, ctrl1}, 32'h12);
      chk("R5 ctrl2 kept", {24'h0, ctrl2}, 32'h34);

      // STOP in the middle of the second data byte
      bus_start();
      wr_byte(8'h90, ack);
      wr_byte(8'hAB, ack);
      for (int i = 0; i < 4; i++) do_bit(1'b1, r);
      bus_stop();
      chk("R10 complete byte kept", {24'h0, ctrl1}, 32'hAB);
      chk("R10 partial byte dropped", {24'h0, ctrl2}, 32'h34);

      // Repeated START from write into read; sense captured at ack
      sense1 = 2'b11; sense2 = 2'b00;
      bus_start();
      wr_byte(8'h90, ack);
      wr_byte(8'h5A, ack);
      bus_start();
      wr_byte(8'h91, ack);
      chk("R10 read after repeated start ack", {31'h0, ack}, 32'h1);
      sense1 = 2'b00; sense2 = 2'b00;
      rd_byte(1'b1, d);
      chk("R8 R7 captured sense", {24'h0, d}, {24'h0, exp_status(1'b0, 2'b11, 2'b00)});
      rd_byte(1'b0, d);
      chk("R8 recapture after master ack", {24'h0, d}, {24'h0, exp_status(1'b0, 2'b00, 2'b00)});
      bus_stop();
      chk("R10 ctrl1 after repeated start", {24'h0, ctrl1}, 32'h5A);
      chk("R10 ctrl2 after repeated start", {24'h0, ctrl2}, 32'h34);

      done = 1'b1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule